// File: doc/BRIEF.md
# Two-Layer Circuit-Switched Tile Switch

This block is the link switch of one tile in a two-dimensional processor mesh. Each of the four compass edges has two inbound and two outbound links, which gives eight of each. The links fall into two layers, and every direction has one link in each layer. Each outbound link is driven by a statically configured multiplexer. The multiplexer picks either the local core or one of the three other directions of the same layer, so a route can pass straight through the tile without involving its core. The core can drive any set of outbound links on a given cycle. It can also receive from any two inbound links, of either layer, through two configurable taps. The core is the only point where the two layers meet.

Every link carries a data word, a valid bit and a request bit that flows back toward the sender. The request returned to each inbound sender is formed from a per-link enable mask. Each receiver's request is first forced high when its enable bit is clear, and the results are then ANDed. A sender therefore stalls until every receiver it cares about is ready, which is what makes broadcast work. Valid is passed on only while that combined request is high, so a broadcast word reaches all of its receivers in the same cycle or none of them. Each outbound link can optionally go through a one-word register stage to break long routes into pipeline steps. All configuration is written through a small register-write port.

Top module: `tile_switch`

## Requirements
- R1: After reset, every outbound multiplexer selects the core, no register stage is enabled, every request mask is clear (so every inbound request is high), core tap p (p = 0, 1) selects inbound link p, and no outbound valid or tap valid is raised while the core and the links are idle.
- R2: Link index = layer*4 + direction, with N=0, E=1, S=2, W=3. An outbound link whose select value k is in 1..3 carries the inbound link of its own layer in direction (own direction + k) mod 4. It never carries a link of the other layer.
- R3: Core tap p presents the data of the inbound link whose 3-bit index it holds, and that index may point to either layer. Its valid is the forwarded valid of that link.
- R4: An outbound link with select value 0 is valid exactly when the core is valid, its bit in the core destination set is high, and the core is ready. It then carries the core's data.
- R5: The core ready output is the AND of the ready signals of the outbound links that are both in the destination set and selecting the core. Outbound links outside that set do not affect it.
- R6: The request returned on an inbound link is the AND, over the 10 receivers, of (receiver ready OR NOT enable bit). Mask bits 0..7 are outbound links 0..7 and bits 8..9 are core taps 0..1. An empty mask leaves the request high.
- R7: An inbound word is forwarded to outbound links and taps only while its returned request is high, so an enabled receiver never sees a word that another enabled receiver is not ready for.
- R8: With its register stage enabled, an outbound link presents a word one cycle after acceptance. It holds that word with unchanged data while its downstream request is low, and it delivers every accepted word exactly once and in order.
- R9: Configuration writes to addresses 18..31 change no configuration state.
- R10: Configuration map: addresses 0..7 set outbound link n as {stage enable in bit 2, select in bits 1:0}; addresses 8..15 set the 10-bit request mask of inbound link (address - 8); addresses 16..17 set the 3-bit link index of core tap (address - 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| lnk_data_i | input | 8x16 | Inbound link data, indexed layer*4+direction |
| lnk_valid_i | input | 8 | Inbound link valid |
| lnk_req_o | output | 8 | Request returned to each inbound sender |
| out_data_o | output | 8x16 | Outbound link data |
| out_valid_o | output | 8 | Outbound link valid |
| out_req_i | input | 8 | Request from each outbound receiver |
| core_data_i | input | 16 | Core outgoing word |
| core_valid_i | input | 1 | Core word valid |
| core_dst_i | input | 8 | Set of outbound links the core drives |
| core_ready_o | output | 1 | All selected core destinations ready |
| cin_data_o | output | 2x16 | Data on the two core taps |
| cin_valid_o | output | 2 | Valid on the two core taps |
| cin_req_i | input | 2 | Core tap ready |

## Verification
Several rules are checked on every cycle against live configuration. An empty mask must leave the returned request high. An enabled tap that is not ready must block its sender. A tap must never show a word its sender is not allowed to send. A core-selecting outbound link must stay quiet while the core is idle. A loaded register stage must hold its word under backpressure. Writes to unmapped addresses must leave the configuration unchanged. Only the bench scenarios can show which source each select value maps to, layer isolation, the reset defaults, and the exact one-cycle latency with in-order, loss-free delivery through a register stage under irregular backpressure.

// File: rtl/tile_switch_pkg.sv
`timescale 1ns/1ps
package tile_switch_pkg;
  localparam int NDIR      = 4;
  localparam int NLAYER    = 2;
  localparam int NLINK     = NDIR * NLAYER;
  localparam int NCPORT    = 2;
  localparam int SEL_W     = $clog2(NDIR);
  localparam int LINK_W    = $clog2(NLINK);
  localparam int RCV_N     = NLINK + NCPORT;
  localparam int CFG_AW    = 5;
  localparam int OCFG_BASE = 0;
  localparam int MASK_BASE = NLINK;
  localparam int CSEL_BASE = 2 * NLINK;
  localparam int CFG_TOP   = CSEL_BASE + NCPORT;

  typedef struct packed {
    logic             pipe;
    logic [SEL_W-1:0] sel;
  } ocfg_t;
endpackage

// File: rtl/tile_switch_cfg.sv
`timescale 1ns/1ps
module tile_switch_cfg
  import tile_switch_pkg::*;
#(
  parameter int CFG_DW = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [CFG_AW-1:0]                 addr_i,
  input  logic [CFG_DW-1:0]                 wdata_i,
  output ocfg_t [NLINK-1:0]                 ocfg_o,
  output logic  [NLINK-1:0][RCV_N-1:0]      mask_o,
  output logic  [NCPORT-1:0][LINK_W-1:0]    csel_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[CFG_DW-1:RCV_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NLINK; n++) begin
        ocfg_o[n] <= '0;
        mask_o[n] <= '0;
      end
      for (int p = 0; p < NCPORT; p++) csel_o[p] <= LINK_W'(p);
    end else if (we_i) begin
      for (int n = 0; n < NLINK; n++) begin
        if (addr_i == CFG_AW'(OCFG_BASE + n)) ocfg_o[n] <= ocfg_t'(wdata_i[$bits(ocfg_t)-1:0]);
        if (addr_i == CFG_AW'(MASK_BASE + n)) mask_o[n] <= wdata_i[RCV_N-1:0];
      end
      for (int p = 0; p < NCPORT; p++)
        if (addr_i == CFG_AW'(CSEL_BASE + p)) csel_o[p] <= wdata_i[LINK_W-1:0];
    end
  end
endmodule

// File: rtl/tile_switch_outport.sv
`timescale 1ns/1ps
module tile_switch_outport
  import tile_switch_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IDX      = 0,
  parameter bit HAS_PIPE = 1'b1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  ocfg_t                         ocfg_i,
  input  logic [DATA_W-1:0]             core_data_i,
  input  logic                          core_valid_i,
  input  logic [NLINK-1:0][DATA_W-1:0]  lnk_data_i,
  input  logic [NLINK-1:0]              lnk_fwd_i,
  input  logic                          out_req_i,
  output logic [DATA_W-1:0]             out_data_o,
  output logic                          out_valid_o,
  output logic                          rdy_o
);
  localparam int LAYER = IDX / NDIR;
  localparam int DIR   = IDX % NDIR;

  logic [LINK_W-1:0] src;
  logic [DATA_W-1:0] in_data;
  logic              in_valid;

  // select 0 = core; k = neighbour (DIR+k) mod NDIR in the same layer
  always_comb begin
    src      = LINK_W'(LAYER * NDIR + ((DIR + int'(ocfg_i.sel)) % NDIR));
    in_data  = core_data_i;
    in_valid = core_valid_i;
    if (ocfg_i.sel != '0) begin
      in_data  = lnk_data_i[src];
      in_valid = lnk_fwd_i[src];
    end
  end

  if (HAS_PIPE) begin : g_stage
    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              take;

    assign take = !full_q || out_req_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (!ocfg_i.pipe) begin
        full_q <= 1'b0;
      end else if (take) begin
        full_q <= in_valid;
        if (in_valid) data_q <= in_data;
      end
    end

    assign out_valid_o = ocfg_i.pipe ? full_q : in_valid;
    assign out_data_o  = ocfg_i.pipe ? data_q : in_data;
    assign rdy_o       = ocfg_i.pipe ? take   : out_req_i;
  end else begin : g_wire
    logic unused_pipe;
    assign unused_pipe = ocfg_i.pipe ^ clk_i ^ rst_ni;
    assign out_valid_o = in_valid;
    assign out_data_o  = in_data;
    assign rdy_o       = out_req_i;
  end
endmodule

// File: rtl/tile_switch.sv
`timescale 1ns/1ps
module tile_switch
  import tile_switch_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CFG_DW   = 16,
  parameter bit HAS_PIPE = 1'b1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cfg_we_i,
  input  logic [CFG_AW-1:0]                 cfg_addr_i,
  input  logic [CFG_DW-1:0]                 cfg_wdata_i,
  input  logic [NLINK-1:0][DATA_W-1:0]      lnk_data_i,
  input  logic [NLINK-1:0]                  lnk_valid_i,
  output logic [NLINK-1:0]                  lnk_req_o,
  output logic [NLINK-1:0][DATA_W-1:0]      out_data_o,
  output logic [NLINK-1:0]                  out_valid_o,
  input  logic [NLINK-1:0]                  out_req_i,
  input  logic [DATA_W-1:0]                 core_data_i,
  input  logic                              core_valid_i,
  input  logic [NLINK-1:0]                  core_dst_i,
  output logic                              core_ready_o,
  output logic [NCPORT-1:0][DATA_W-1:0]     cin_data_o,
  output logic [NCPORT-1:0]                 cin_valid_o,
  input  logic [NCPORT-1:0]                 cin_req_i
);
  ocfg_t [NLINK-1:0]              ocfg;
  logic  [NLINK-1:0][RCV_N-1:0]   mask;
  logic  [NCPORT-1:0][LINK_W-1:0] csel;
  logic  [NLINK-1:0]              out_rdy;
  logic  [NLINK-1:0]              lnk_fwd;
  logic  [NLINK-1:0]              core_use;
  logic  [RCV_N-1:0]              rcv_rdy;
  logic                           core_go;

  tile_switch_cfg #(.CFG_DW(CFG_DW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .ocfg_o  (ocfg),
    .mask_o  (mask),
    .csel_o  (csel)
  );

  // masked-request AND: a receiver with a clear enable never blocks
  assign rcv_rdy = {cin_req_i, out_rdy};
  always_comb begin
    for (int i = 0; i < NLINK; i++) lnk_req_o[i] = &(~mask[i] | rcv_rdy);
  end
  assign lnk_fwd = lnk_valid_i & lnk_req_o;

  always_comb begin
    for (int n = 0; n < NLINK; n++) core_use[n] = core_dst_i[n] && (ocfg[n].sel == '0);
  end
  assign core_ready_o = &(~core_use | out_rdy);
  assign core_go      = core_valid_i && core_ready_o;

  for (genvar n = 0; n < NLINK; n++) begin : g_out
    tile_switch_outport #(
      .DATA_W   (DATA_W),
      .IDX      (n),
      .HAS_PIPE (HAS_PIPE)
    ) u_out (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ocfg_i       (ocfg[n]),
      .core_data_i  (core_data_i),
      .core_valid_i (core_go && core_dst_i[n]),
      .lnk_data_i   (lnk_data_i),
      .lnk_fwd_i    (lnk_fwd),
      .out_req_i    (out_req_i[n]),
      .out_data_o   (out_data_o[n]),
      .out_valid_o  (out_valid_o[n]),
      .rdy_o        (out_rdy[n])
    );
  end

  always_comb begin
    for (int p = 0; p < NCPORT; p++) begin
      cin_data_o[p]  = lnk_data_i[csel[p]];
      cin_valid_o[p] = lnk_fwd[csel[p]];
    end
  end
endmodule

// File: rtl/tile_switch_chk.sv
`timescale 1ns/1ps
module tile_switch_chk
  import tile_switch_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter bit HAS_PIPE = 1'b1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cfg_we_i,
  input  logic [CFG_AW-1:0]                 cfg_addr_i,
  input  logic [NLINK-1:0]                  lnk_valid_i,
  input  logic [NLINK-1:0]                  lnk_req_o,
  input  logic [NLINK-1:0][DATA_W-1:0]      out_data_o,
  input  logic [NLINK-1:0]                  out_valid_o,
  input  logic [NLINK-1:0]                  out_req_i,
  input  logic                              core_valid_i,
  input  logic [NLINK-1:0]                  core_dst_i,
  input  logic                              core_ready_o,
  input  logic [NCPORT-1:0]                 cin_valid_o,
  input  logic [NCPORT-1:0]                 cin_req_i,
  input  ocfg_t [NLINK-1:0]                 ocfg_i,
  input  logic  [NLINK-1:0][RCV_N-1:0]      mask_i,
  input  logic  [NCPORT-1:0][LINK_W-1:0]    csel_i
);
  logic unused_data;
  assign unused_data = ^out_data_o;

  for (genvar i = 0; i < NLINK; i++) begin : g_lnk
    AST_REQ_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_i[i] == '0) |-> lnk_req_o[i]); // R6
    for (genvar p = 0; p < NCPORT; p++) begin : g_tap
      AST_REQ_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i[i][NLINK+p] && !cin_req_i[p]) |-> !lnk_req_o[i]); // R6
    end
  end

  for (genvar n = 0; n < NLINK; n++) begin : g_o
    AST_CORE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ocfg_i[n].sel == '0 && !ocfg_i[n].pipe && !core_valid_i) |-> !out_valid_o[n]); // R4
    AST_CORE_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_ready_o && core_dst_i[n] && ocfg_i[n].sel == '0 && !ocfg_i[n].pipe) |-> out_req_i[n]); // R5
    if (HAS_PIPE) begin : g_pp
      AST_PIPE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ocfg_i[n].pipe && out_valid_o[n] && !out_req_i[n] && !cfg_we_i)
        |=> (out_valid_o[n] && $stable(out_data_o[n]))); // R8
    end
  end

  for (genvar p = 0; p < NCPORT; p++) begin : g_c
    AST_TAP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cin_valid_o[p] |-> (lnk_valid_i[csel_i[p]] && lnk_req_o[csel_i[p]])); // R7
    AST_TAP_NO_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cin_valid_o[p] && mask_i[csel_i[p]][NLINK+p]) |-> cin_req_i[p]); // R7
  end

  AST_CFG_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i >= CFG_AW'(CFG_TOP))
    |=> ($stable(ocfg_i) && $stable(mask_i) && $stable(csel_i))); // R9
  AST_CFG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(ocfg_i) && $stable(mask_i) && $stable(csel_i))); // R10
endmodule

bind tile_switch tile_switch_chk #(.DATA_W(DATA_W), .HAS_PIPE(HAS_PIPE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_addr_i   (cfg_addr_i),
  .lnk_valid_i  (lnk_valid_i),
  .lnk_req_o    (lnk_req_o),
  .out_data_o   (out_data_o),
  .out_valid_o  (out_valid_o),
  .out_req_i    (out_req_i),
  .core_valid_i (core_valid_i),
  .core_dst_i   (core_dst_i),
  .core_ready_o (core_ready_o),
  .cin_valid_o  (cin_valid_o),
  .cin_req_i    (cin_req_i),
  .ocfg_i       (ocfg),
  .mask_i       (mask),
  .csel_i       (csel)
);

// File: tb/tile_switch_bench.sv
`timescale 1ns/1ps
module tile_switch_bench;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [4:0]       cfg_addr = '0;
  logic [15:0]      cfg_wdata = '0;
  logic [7:0][15:0] lnk_data;
  logic [7:0]       lnk_valid = '0;
  logic [7:0]       lnk_req;
  logic [7:0][15:0] out_data;
  logic [7:0]       out_valid;
  logic [7:0]       out_req = 8'hFF;
  logic [15:0]      core_data = '0;
  logic             core_valid = 1'b0;
  logic [7:0]       core_dst = '0;
  logic             core_ready;
  logic [1:0][15:0] cin_data;
  logic [1:0]       cin_valid;
  logic [1:0]       cin_req = 2'b11;

  int n_chk = 0;
  int n_bad = 0;
  int n_pop = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [15:0] sb_q[$];

  always #2.5 clk = ~clk;

  tile_switch u_tile_switch (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .lnk_data_i(lnk_data), .lnk_valid_i(lnk_valid), .lnk_req_o(lnk_req),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_req_i(out_req),
    .core_data_i(core_data), .core_valid_i(core_valid), .core_dst_i(core_dst),
    .core_ready_o(core_ready),
    .cin_data_o(cin_data), .cin_valid_o(cin_valid), .cin_req_i(cin_req)
  );

  function automatic logic [15:0] dval(input int i);
    return 16'(16'h1010 * i + 3);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // monitor: pops expected words as the piped outbound link 3 delivers them
  always begin
    @(negedge clk);
    #2;
    if (mon_en && out_valid[3] && out_req[3]) begin
      n_pop++;
      if (sb_q.size() == 0) chk("R8 unexpected word", 32'(out_data[3]), 32'hFFFF_FFFF);
      else chk("R8 stream order", 32'(out_data[3]), 32'(sb_q.pop_front()));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    for (int i = 0; i < 8; i++) lnk_data[i] = dval(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 out_valid idle", 32'(out_valid), 32'h0);
    chk("R1 tap valid idle", 32'(cin_valid), 32'h0);
    chk("R1 requests open", 32'(lnk_req), 32'hFF);
    chk("R1 core ready", 32'(core_ready), 32'h1);
    @(negedge clk);
    lnk_valid = 8'h02;
    #1;
    chk("R1 tap1 default link1 valid", 32'(cin_valid), 32'h2);
    chk("R1 tap1 default link1 data", 32'(cin_data[1]), 32'(dval(1)));
    @(negedge clk);
    lnk_valid = '0; core_valid = 1'b1; core_data = 16'hA5A5; core_dst = 8'hFF;
    #1;
    chk("R1 all outputs select core", 32'(out_valid), 32'hFF);
    // R4 core drives a chosen set
    @(negedge clk);
    core_dst = 8'b0100_0101;
    #1;
    chk("R4 core set valid", 32'(out_valid), 32'h45);
    chk("R4 core data on out6", 32'(out_data[6]), 32'hA5A5);
    // R5 / R7 core readiness
    @(negedge clk);
    out_req[2] = 1'b0;
    #1;
    chk("R5 blocked by selected out2", 32'(core_ready), 32'h0);
    chk("R7 no partial core broadcast", 32'(out_valid), 32'h0);
    @(negedge clk);
    out_req = 8'hFD;
    #1;
    chk("R5 unselected out1 ignored", 32'(core_ready), 32'h1);
    chk("R5 core set still valid", 32'(out_valid), 32'h45);
    @(negedge clk);
    core_valid = 1'b0; core_dst = '0; out_req = 8'hFF;
    // R10 / R2 output mux
    cfg_wr(5'd1, 16'h0001);  // out1 (L0 E) -> L0 S = link2
    cfg_wr(5'd5, 16'h0003);  // out5 (L1 E) -> L1 N = link4
    cfg_wr(5'd7, 16'h0002);  // out7 (L1 W) -> L1 E = link5
    lnk_valid = 8'b0011_0100;
    #1;
    chk("R2 routed valid set", 32'(out_valid), 32'hA2);
    chk("R2 out1 from link2", 32'(out_data[1]), 32'(dval(2)));
    chk("R2 out5 from link4", 32'(out_data[5]), 32'(dval(4)));
    chk("R10 out7 from link5", 32'(out_data[7]), 32'(dval(5)));
    @(negedge clk);
    lnk_valid = 8'b0000_0001;
    #1;
    chk("R2 layer0 link never reaches layer1", 32'(out_valid), 32'h0);
    // R6 / R7 masked requests: link2 waits on out1 (bit1) and tap0 (bit8)
    cfg_wr(5'd10, 16'h0102);
    lnk_valid = 8'h04; cin_req = 2'b10;
    #1;
    chk("R6 tap0 not ready blocks", 32'(lnk_req[2]), 32'h0);
    chk("R7 out1 withheld", 32'(out_valid[1]), 32'h0);
    @(negedge clk);
    cin_req = 2'b11; out_req[1] = 1'b0;
    #1;
    chk("R6 out1 not ready blocks", 32'(lnk_req[2]), 32'h0);
    @(negedge clk);
    out_req = 8'hF7;
    #1;
    chk("R6 unmasked out3 ignored", 32'(lnk_req[2]), 32'h1);
    chk("R7 out1 forwarded", 32'(out_valid[1]), 32'h1);
    @(negedge clk);
    out_req = 8'hFF; lnk_valid = '0;
    // R3 core taps
    cfg_wr(5'd17, 16'h0006);
    cfg_wr(5'd16, 16'h0005);
    lnk_valid = 8'h40;
    #1;
    chk("R3 tap1 on link6 valid", 32'(cin_valid), 32'h2);
    chk("R3 tap1 on link6 data", 32'(cin_data[1]), 32'(dval(6)));
    @(negedge clk);
    lnk_valid = 8'h20;
    #1;
    chk("R3 tap0 crosses to layer1 link5", 32'(cin_valid), 32'h1);
    chk("R3 tap0 data", 32'(cin_data[0]), 32'(dval(5)));
    // R9 unmapped writes
    @(negedge clk);
    lnk_valid = '0;
    cfg_wr(5'd20, 16'h0000);
    cfg_wr(5'd31, 16'hFFFF);
    cfg_wr(5'd18, 16'h0000);
    lnk_valid = 8'hFF;
    #1;
    chk("R9 out1 still link2", 32'(out_data[1]), 32'(dval(2)));
    chk("R9 out5 still link4", 32'(out_data[5]), 32'(dval(4)));
    chk("R9 tap1 still link6", 32'(cin_data[1]), 32'(dval(6)));
    chk("R9 tap0 still link5", 32'(cin_data[0]), 32'(dval(5)));
    chk("R9 link2 mask still active", 32'(lnk_req[2]), 32'h1);
    // R8 register stage on out3
    @(negedge clk);
    lnk_valid = '0;
    cfg_wr(5'd3, 16'h0004);
    core_dst = 8'h08; core_data = 16'hBEEF; core_valid = 1'b1;
    #1;
    chk("R8 accepted", 32'(core_ready), 32'h1);
    chk("R8 not combinational", 32'(out_valid[3]), 32'h0);
    @(negedge clk);
    core_valid = 1'b0; out_req[3] = 1'b0;
    #1;
    chk("R8 one-cycle latency valid", 32'(out_valid[3]), 32'h1);
    chk("R8 one-cycle latency data", 32'(out_data[3]), 32'hBEEF);
    @(negedge clk);
    core_valid = 1'b1; core_data = 16'hCAFE;
    #1;
    chk("R8 hold valid", 32'(out_valid[3]), 32'h1);
    chk("R8 hold data", 32'(out_data[3]), 32'hBEEF);
    chk("R8 full stage stalls core", 32'(core_ready), 32'h0);
    @(negedge clk);
    core_valid = 1'b0; out_req[3] = 1'b1;
    #1;
    chk("R8 drain pending", 32'(out_data[3]), 32'hBEEF);
    step();
    chk("R8 drained once", 32'(out_valid[3]), 32'h0);
    // R8 scoreboard stream under irregular backpressure
    mon_en = 1'b1;
    w = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      core_valid = (k % 5) != 4;
      core_data = 16'(16'h4000 + w);
      out_req[3] = ((k % 4) != 1) && ((k % 7) != 3);
      #1;
      if (core_valid && core_ready) begin
        sb_q.push_back(core_data);
        w++;
      end
    end
    @(negedge clk);
    core_valid = 1'b0; out_req[3] = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    chk("R8 queue empty", 32'(sb_q.size()), 32'h0);
    chk("R8 all words delivered", 32'(n_pop), 32'(w));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule